// File: doc/BRIEF.md
# Instruction Loop Cache Controller

This block sits between program-memory fetch and the instruction decoder and runs a short block of N instructions K times. A capture command records the next N instructions arriving from memory, issuing them as they arrive, and then replays them from its own storage. A replay command runs the block already held K more times, with no memory traffic for the replayed words. Each issued word carries a flag telling the decoder whether it came from the cache or from memory, and a stretch flag asking for the instruction to take two cycles.

Timing across passes is deliberately uneven. On the capturing pass every word comes from memory, and the last word of the block is stretched to two cycles. Middle passes come entirely from the cache. On the final pass the first N-1 words come from the cache, and the last word is fetched from memory again. To make that fetch land on the right word, the block sends the fetch unit a program-counter redirect. At the end of every non-final pass this redirect points to the loop start address. Just before the final memory fetch it points to start+N-1. Interrupts are inhibited while a loop runs. A word marked non-cachable by predecode aborts a capture.

Top module: `lc_loop_cache`

## Requirements
- R1: During a capture pass, each word accepted from memory is issued with `iss_from_cache`=0, in arrival order, and is also written into storage at the next block position.
- R2: In the capture pass, the last word of the block is issued with `iss_stretch`=1. No other issued word carries the stretch flag.
- R3: On every pass strictly between the first and the final one, all N words are issued from storage (`iss_from_cache`=1) in block order.
- R4: On the final pass, words 0..N-2 come from storage and word N-1 is the next word accepted from memory. With K=1 on a capture, the single pass is the capture pass itself and issues N words from memory only.
- R5: A one-cycle `pc_load` with `pc_addr` = start address follows every pass that is not the final one. A `pc_load` with `pc_addr` = start+N-1 comes before the final memory fetch. A capture with K=1 produces no `pc_load`.
- R6: `cmd_replay` with a valid held block runs it `cmd_k` times and loads nothing new into storage. Its first pass is taken from storage, with no stretch.
- R7: `int_inhibit` is 1 in every cycle in which a loop word is issued, and it is 0 once the loop has ended.
- R8: A word with `mem_cachable`=0 seen during capture is not issued. It causes a one-cycle `err`, ends the loop and leaves no valid held block.
- R9: `cmd_replay` when no valid block is held issues nothing and raises `err` for exactly one cycle.
- R10: A capture with `cmd_n`=0, `cmd_n` greater than DEPTH, or `cmd_k`=0 is rejected with a one-cycle `err` and no issue.
- R11: Commands that arrive while a loop is active are ignored without `err`, and the running loop's issue sequence is unchanged.
- R12: While `mem_valid`=0, a capture pass or the final memory fetch waits and issues nothing, with `int_inhibit` held at 1.
- R13: After reset, `iss_valid`, `pc_load`, `err` and `int_inhibit` are 0, and no valid block is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_capture | input | 1 | Start a loop that captures the next N words |
| cmd_replay | input | 1 | Rerun the held block K times |
| cmd_n | input | NW | Block length N |
| cmd_k | input | KW | Pass count K |
| cmd_pc | input | AW | Address of the first word of the block |
| mem_valid | input | 1 | A fetched word is presented |
| mem_word | input | W | Fetched instruction word |
| mem_cachable | input | 1 | Predecode says the word may be held |
| iss_valid | output | 1 | A loop word is issued this cycle |
| iss_word | output | W | Issued word |
| iss_from_cache | output | 1 | Issued word came from storage |
| iss_stretch | output | 1 | Issued word must take two cycles |
| pc_load | output | 1 | Redirect the fetch program counter |
| pc_addr | output | AW | Redirect target |
| int_inhibit | output | 1 | Interrupts held off |
| err | output | 1 | One-cycle error pulse |

## Verification
The bench builds the block with its defaults: 15 storage entries, 16-bit words and addresses, and a 7-bit pass count. With those values a block can fill the storage exactly (N=15) and can also shrink to N=1, where the first and last word coincide and the final pass has no storage issues at all. Small pass counts (K=1, 2, 3, 4) are enough to cover each pass shape: capture-only, capture followed by the final pass, and runs with middle passes. The bench also stalls memory during capture and during the final fetch.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_LAST
  } lc_state_e;
endpackage

// File: rtl/lc_store.sv
// Loop word storage: one write port, one registered read port (block RAM style).
module lc_store #(
  parameter int DEPTH = 15,
  parameter int W     = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lc_pass_ctr.sv
// Position-in-block and pass counters.
module lc_pass_ctr #(
  parameter int IW = 4,
  parameter int KW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          advance,
  input  logic [IW-1:0] last_idx,
  input  logic [KW-1:0] k_total,
  output logic [IW-1:0] idx,
  output logic [KW-1:0] pass,
  output logic          at_last,
  output logic          at_final
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      pass <= '0;
    end else if (start) begin
      idx  <= '0;
      pass <= KW'(1);
    end else if (advance) begin
      if (idx == last_idx) begin
        idx  <= '0;
        pass <= pass + KW'(1);
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end

  assign at_last  = (idx == last_idx);
  assign at_final = (pass == k_total);

  // R3: the position never runs past the end of the block
  a_r3_idx_within_block: assert property (@(posedge clk) disable iff (rst)
    advance |-> (idx <= last_idx));

  // R4: no pass is stepped beyond the requested pass count
  a_r4_pass_within_count: assert property (@(posedge clk) disable iff (rst)
    advance |-> (pass <= k_total));
endmodule

// File: rtl/lc_loop_cache.sv
module lc_loop_cache #(
  parameter int DEPTH = 15,
  parameter int W     = 16,
  parameter int AW    = 16,
  parameter int KW    = 7,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_capture,
  input  logic          cmd_replay,
  input  logic [NW-1:0] cmd_n,
  input  logic [KW-1:0] cmd_k,
  input  logic [AW-1:0] cmd_pc,
  input  logic          mem_valid,
  input  logic [W-1:0]  mem_word,
  input  logic          mem_cachable,
  output logic          iss_valid,
  output logic [W-1:0]  iss_word,
  output logic          iss_from_cache,
  output logic          iss_stretch,
  output logic          pc_load,
  output logic [AW-1:0] pc_addr,
  output logic          int_inhibit,
  output logic          err
);
  import lc_pkg::*;

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lc_state_e       state_q, state_d;
  logic [NW-1:0]   n_q;
  logic [KW-1:0]   k_q;
  logic [AW-1:0]   base_q;
  logic            held_q;
  logic [IW-1:0]   last_idx;
  logic [IW-1:0]   idx;
  logic [KW-1:0]   pass;
  logic            at_last, at_final;
  logic            ctr_start, ctr_adv;
  logic            wr_en, rd_en;
  logic [W-1:0]    cache_q;
  logic [W-1:0]    word_q;

  logic            cfg_ok;
  logic            take_cfg, take_k, set_held, clr_held;
  logic            ov_d, oc_d, os_d, pl_d, err_d;
  logic [W-1:0]    ow_d;
  logic [AW-1:0]   pa_d;

  assign last_idx = IW'(n_q - NW'(1));
  assign cfg_ok   = (cmd_n != '0) && (cmd_n <= NW'(DEPTH)) && (cmd_k != '0);

  lc_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (idx),
    .wdata (mem_word),
    .re    (rd_en),
    .raddr (idx),
    .rdata (cache_q)
  );

  lc_pass_ctr #(.IW(IW), .KW(KW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .start    (ctr_start),
    .advance  (ctr_adv),
    .last_idx (last_idx),
    .k_total  (k_q),
    .idx      (idx),
    .pass     (pass),
    .at_last  (at_last),
    .at_final (at_final)
  );

  always_comb begin
    state_d   = state_q;
    take_cfg  = 1'b0;
    take_k    = 1'b0;
    set_held  = 1'b0;
    clr_held  = 1'b0;
    ctr_start = 1'b0;
    ctr_adv   = 1'b0;
    wr_en     = 1'b0;
    rd_en     = 1'b0;
    ov_d      = 1'b0;
    oc_d      = 1'b0;
    os_d      = 1'b0;
    ow_d      = word_q;
    pl_d      = 1'b0;
    pa_d      = pc_addr;
    err_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_capture) begin
          if (cfg_ok) begin
            take_cfg  = 1'b1;
            clr_held  = 1'b1;
            ctr_start = 1'b1;
            state_d   = ST_LOAD;
          end else begin
            err_d = 1'b1;
          end
        end else if (cmd_replay) begin
          if (held_q && (cmd_k != '0)) begin
            take_k    = 1'b1;
            ctr_start = 1'b1;
            state_d   = ST_RUN;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (mem_valid) begin
          if (!mem_cachable) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            wr_en = 1'b1;
            ov_d  = 1'b1;
            ow_d  = mem_word;
            if (at_last) begin
              os_d = 1'b1;
              if (k_q == KW'(1)) begin
                set_held = 1'b1;
                state_d  = ST_IDLE;
              end else begin
                pl_d    = 1'b1;
                pa_d    = base_q;
                ctr_adv = 1'b1;
                state_d = ST_RUN;
              end
            end else begin
              ctr_adv = 1'b1;
            end
          end
        end
      end
      ST_RUN: begin
        if (at_final && at_last) begin
          pl_d    = 1'b1;
          pa_d    = base_q + AW'(last_idx);
          state_d = ST_LAST;
        end else begin
          rd_en   = 1'b1;
          ov_d    = 1'b1;
          oc_d    = 1'b1;
          ctr_adv = 1'b1;
          if (at_last) begin
            pl_d = 1'b1;
            pa_d = base_q;
          end
        end
      end
      ST_LAST: begin
        if (mem_valid) begin
          ov_d     = 1'b1;
          ow_d     = mem_word;
          set_held = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      n_q            <= NW'(1);
      k_q            <= KW'(1);
      base_q         <= '0;
      held_q         <= 1'b0;
      iss_valid      <= 1'b0;
      iss_from_cache <= 1'b0;
      iss_stretch    <= 1'b0;
      word_q         <= '0;
      pc_load        <= 1'b0;
      pc_addr        <= '0;
      int_inhibit    <= 1'b0;
      err            <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_cfg) begin
        n_q    <= cmd_n;
        k_q    <= cmd_k;
        base_q <= cmd_pc;
      end else if (take_k) begin
        k_q <= cmd_k;
      end
      if (clr_held)      held_q <= 1'b0;
      else if (set_held) held_q <= 1'b1;
      iss_valid      <= ov_d;
      iss_from_cache <= oc_d;
      iss_stretch    <= os_d;
      word_q         <= ow_d;
      pc_load        <= pl_d;
      pc_addr        <= pa_d;
      int_inhibit    <= (state_d != ST_IDLE) || ov_d;
      err            <= err_d;
    end
  end

  assign iss_word = iss_from_cache ? cache_q : word_q;

  // R7: every issued loop word is covered by the interrupt inhibit
  a_r7_issue_inhibited: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> int_inhibit);

  // R2: a stretched word is always a real issue taken from memory
  a_r2_stretch_from_mem: assert property (@(posedge clk) disable iff (rst)
    iss_stretch |-> (iss_valid && !iss_from_cache));

  // R9: an error cycle never carries an issued word
  a_r9_err_silent: assert property (@(posedge clk) disable iff (rst)
    err |-> !iss_valid);

  // R11: block length and start address stay frozen while a loop is active
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> ($stable(n_q) && $stable(base_q)));

  // R5: fetch redirects only happen inside an active loop
  a_r5_redirect_in_loop: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> int_inhibit);
endmodule

// File: tb/tb_lc_loop_cache.sv
module tb_lc_loop_cache;
  localparam int DEPTH = 15;
  localparam int W     = 16;
  localparam int AW    = 16;
  localparam int KW    = 7;
  localparam int NW    = $clog2(DEPTH + 1);
  localparam logic [W-1:0] MARK = 16'hBEEF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_capture = 1'b0;
  logic          cmd_replay = 1'b0;
  logic [NW-1:0] cmd_n = '0;
  logic [KW-1:0] cmd_k = '0;
  logic [AW-1:0] cmd_pc = '0;
  logic          mem_valid = 1'b0;
  logic [W-1:0]  mem_word = '0;
  logic          mem_cachable = 1'b1;
  logic          iss_valid, iss_from_cache, iss_stretch, pc_load, int_inhibit, err;
  logic [W-1:0]  iss_word;
  logic [AW-1:0] pc_addr;

  always #10 clk = ~clk;

  lc_loop_cache #(.DEPTH(DEPTH), .W(W), .AW(AW), .KW(KW)) dut (
    .clk(clk), .rst(rst), .cmd_capture(cmd_capture), .cmd_replay(cmd_replay),
    .cmd_n(cmd_n), .cmd_k(cmd_k), .cmd_pc(cmd_pc), .mem_valid(mem_valid),
    .mem_word(mem_word), .mem_cachable(mem_cachable), .iss_valid(iss_valid),
    .iss_word(iss_word), .iss_from_cache(iss_from_cache), .iss_stretch(iss_stretch),
    .pc_load(pc_load), .pc_addr(pc_addr), .int_inhibit(int_inhibit), .err(err)
  );

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  logic [W-1:0]  rw [256];
  logic          rc [256];
  logic          rs [256];
  logic [AW-1:0] pa [16];
  int rn = 0, pn = 0, errn = 0, errlong = 0, viol = 0;
  logic prev_err = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (iss_valid) begin
        if (rn < 256) begin
          rw[rn] = iss_word; rc[rn] = iss_from_cache; rs[rn] = iss_stretch;
        end
        rn++;
        if (!int_inhibit) viol++;
      end
      if (pc_load) begin
        if (pn < 16) pa[pn] = pc_addr;
        pn++;
      end
      if (err) errn++;
      if (err && prev_err) errlong++;
      prev_err = err;
    end
  end

  task automatic clear_rec();
    rn = 0; pn = 0; errn = 0; errlong = 0; viol = 0;
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int c);
    repeat (c) @(negedge clk);
  endtask

  // Compare the recorded issue stream with the pass shapes of R1..R6.
  task automatic check_seq(string req, int n, int k, logic [AW-1:0] base, bit replay);
    int exp_n, mism, exp_pn;
    logic [W-1:0] ew;
    logic ec, es;
    longint act_v, exp_v;
    exp_n = n * k;
    mism = -1; act_v = 0; exp_v = 0;
    chk(rn == exp_n, req, "issue count", rn, exp_n);
    for (int j = 0; j < rn && j < exp_n; j++) begin
      int p = j / n;
      int i = j % n;
      if (!replay && p == 0) begin
        ew = W'(16'h1000) + W'(base) + W'(i); ec = 1'b0; es = (i == n - 1);
      end else if (p == k - 1 && i == n - 1) begin
        ew = MARK; ec = 1'b0; es = 1'b0;
      end else begin
        ew = W'(16'h1000) + W'(base) + W'(i); ec = 1'b1; es = 1'b0;
      end
      if (mism < 0 && (rw[j] != ew || rc[j] != ec || rs[j] != es)) begin
        mism = j;
        act_v = {rc[j], rs[j], rw[j]};
        exp_v = {ec, es, ew};
      end
    end
    chk(mism < 0, req, "word/source/stretch", act_v, exp_v);
    exp_pn = (!replay && k == 1) ? 0 : k;
    chk(pn == exp_pn, "R5", "redirect count", pn, exp_pn);
    if (exp_pn > 0 && pn == exp_pn) begin
      chk(pa[pn-1] == base + AW'(n - 1), "R5", "final redirect address", pa[pn-1], base + AW'(n - 1));
      if (k >= 2) chk(pa[0] == base, "R5", "pass-end redirect address", pa[0], base);
    end
    chk(viol == 0, "R7", "issue without inhibit", viol, 0);
    chk(int_inhibit == 1'b0, "R7", "inhibit after loop", int_inhibit, 0);
    chk(errn == 0, req, "unexpected err", errn, 0);
  endtask

  // Capture N words and run K passes; bad marks a non-cachable position.
  task automatic run_capture(int n, int k, logic [AW-1:0] base, int bad, bit stall, bit poke);
    @(posedge clk); clear_rec();
    @(negedge clk);
    cmd_capture = 1'b1; cmd_n = NW'(n); cmd_k = KW'(k); cmd_pc = base;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_capture = 1'b0;
      if (stall) begin mem_valid = 1'b0; @(negedge clk); end
      mem_valid = 1'b1;
      mem_word = W'(16'h1000) + W'(base) + W'(i);
      mem_cachable = (i != bad);
    end
    @(negedge clk);
    cmd_capture = 1'b0; mem_word = MARK; mem_cachable = 1'b1;
    mem_valid = !stall;
    if (poke) begin
      cmd_replay = 1'b1; cmd_capture = 1'b1; cmd_n = NW'(1); cmd_k = KW'(1);
      @(negedge clk);
      cmd_replay = 1'b0; cmd_capture = 1'b0;
    end
    cyc(n * k + 8);
    if (stall && k >= 2) begin
      chk(rn == n * k - 1, "R12", "issues while final fetch stalled", rn, n * k - 1);
      chk(int_inhibit == 1'b1, "R12", "inhibit while stalled", int_inhibit, 1);
      mem_valid = 1'b1;
      cyc(6);
    end
    mem_valid = 1'b0;
  endtask

  task automatic run_replay(int n, int k);
    @(posedge clk); clear_rec();
    @(negedge clk);
    cmd_replay = 1'b1; cmd_k = KW'(k);
    @(negedge clk);
    cmd_replay = 1'b0; mem_valid = 1'b1; mem_word = MARK; mem_cachable = 1'b1;
    cyc(n * k + 8);
    mem_valid = 1'b0;
  endtask

  task automatic bad_capture(int n, int k, string what);
    @(posedge clk); clear_rec();
    @(negedge clk);
    cmd_capture = 1'b1; cmd_n = NW'(n); cmd_k = KW'(k);
    @(negedge clk);
    cmd_capture = 1'b0; mem_valid = 1'b1; mem_word = 16'h2222;
    cyc(6);
    mem_valid = 1'b0;
    chk(rn == 0, "R10", {what, " issue count"}, rn, 0);
    chk(errn == 1, "R10", {what, " err cycles"}, errn, 1);
    chk(int_inhibit == 1'b0, "R10", {what, " inhibit"}, int_inhibit, 0);
  endtask

  task automatic t_reset();
    cyc(3); rst = 1'b0; cyc(2);
    chk(iss_valid == 1'b0, "R13", "iss_valid after reset", iss_valid, 0);
    chk(pc_load == 1'b0, "R13", "pc_load after reset", pc_load, 0);
    chk(err == 1'b0, "R13", "err after reset", err, 0);
    chk(int_inhibit == 1'b0, "R13", "int_inhibit after reset", int_inhibit, 0);
  endtask

  task automatic t_replay_empty();
    run_replay(1, 2);
    chk(rn == 0, "R9", "issues on empty replay", rn, 0);
    chk(errn == 1, "R9", "err cycles on empty replay", errn, 1);
    chk(errlong == 0, "R9", "err longer than one cycle", errlong, 0);
  endtask

  task automatic t_noncachable();
    run_capture(5, 3, 16'h0300, 2, 1'b0, 1'b0);
    chk(rn == 2, "R8", "issues before abort", rn, 2);
    chk(errn == 1 && errlong == 0, "R8", "single err pulse", errn, 1);
    chk(int_inhibit == 1'b0, "R8", "inhibit after abort", int_inhibit, 0);
    run_replay(5, 2);
    chk(rn == 0, "R8", "replay after abort issues", rn, 0);
    chk(errn == 1, "R8", "replay after abort err", errn, 1);
  endtask

  initial begin
    t_reset();
    t_replay_empty();
    run_capture(4, 3, 16'h0040, -1, 1'b0, 1'b0);
    check_seq("R1 R2 R3 R4", 4, 3, 16'h0040, 1'b0);
    run_replay(4, 2);
    check_seq("R6", 4, 2, 16'h0040, 1'b1);
    run_capture(1, 1, 16'h0080, -1, 1'b0, 1'b0);
    check_seq("R4 single pass", 1, 1, 16'h0080, 1'b0);
    run_capture(15, 2, 16'h0100, -1, 1'b1, 1'b0);
    check_seq("R12 R1", 15, 2, 16'h0100, 1'b0);
    run_replay(15, 1);
    check_seq("R6 R4", 15, 1, 16'h0100, 1'b1);
    run_capture(1, 3, 16'h0200, -1, 1'b0, 1'b0);
    check_seq("R3 R2", 1, 3, 16'h0200, 1'b0);
    t_noncachable();
    bad_capture(0, 2, "zero length");
    bad_capture(0, 0, "zero count");
    bad_capture(3, 0, "zero pass count");
    run_capture(3, 4, 16'h0400, -1, 1'b0, 1'b1);
    check_seq("R11", 3, 4, 16'h0400, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule